// File: doc/BRIEF.md
# Operate Unit with Sign Condition Register

This block executes the three arithmetic and logic instructions of a small 16-bit accumulator-free architecture: addition, bitwise AND and bitwise complement. The operands come from an internal file of eight 16-bit general registers. Each accepted instruction writes its result back to the register file and updates a one-hot condition register. The condition register records whether the last value written was negative, zero or positive, so that a later conditional branch stage can test it.

An upstream fetch and decode stage presents one 16-bit instruction word with a valid strobe per clock. The block does no fetch, memory access or control flow. Any word that is not one of the three operate instructions is dropped without touching any state. A registered write-back view reports each write one cycle after the instruction is presented. A combinational debug read port exposes any register, and the results of an instruction can be used by the instruction in the very next cycle.

The write-back view is driven by a two-state machine. `ST_IDLE` means no write happened at the last edge, and `ST_WB` means a write did. The machine takes `ST_IDLE -> ST_WB` and `ST_WB -> ST_WB` when a legal operate instruction is accepted. It takes `ST_WB -> ST_IDLE` and `ST_IDLE -> ST_IDLE` otherwise.

Top module: `opu_core`

## Requirements
- R1: While and after reset (active-low `rst_n`), all eight registers read zero, `cc_flags` is 3'b010 (Z) and `wb_en` is low.
- R2: With `instr_valid` high, a word with bits [15:12]=4'b0001 and bit 5=0 writes register[bits 11:9] = register[bits 8:6] + register[bits 2:0], modulo 2^16; bits [4:3] are don't-care.
- R3: With bits [15:12]=4'b0001 and bit 5=1, the second operand is bits [4:0] sign-extended to 16 bits, so an immediate of zero copies the source register to the destination.
- R4: Bits [15:12]=4'b0101 performs a bitwise AND with the same two operand forms as R2 and R3, so an immediate of zero clears the destination.
- R5: Bits [15:12]=4'b1001 with bits [5:0]=6'b111111 writes register[11:9] = bitwise complement of register[8:6].
- R6: Source and destination fields may name the same register; the operation uses the value held before the edge that writes the result.
- R7: `cc_flags` = {N,Z,P} always has exactly one bit set, and it is updated at the same edge as the register write: N when bit 15 of the result is 1, Z when the result is zero, P otherwise.
- R8: With `instr_valid` low, or with an opcode other than 4'b0001, 4'b0101 or 4'b1001, no register changes, `cc_flags` holds and `wb_en` is low in the next cycle.
- R9: A word with opcode 4'b1001 whose bits [5:0] are not all ones is ignored in the same way as R8.
- R10: In the cycle after an instruction is accepted, `wb_en` is high and `wb_idx`/`wb_data` give the destination index and the value written.
- R11: The result of an instruction is visible to an instruction presented in the immediately following cycle and on the debug port in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 16 | Instruction to execute |
| wb_en | output | 1 | A register was written at the last edge |
| wb_idx | output | 3 | Index of the register last written |
| wb_data | output | 16 | Value last written |
| cc_flags | output | 3 | Condition register {N,Z,P}, one-hot |
| dbg_idx | input | 3 | Register selected for the debug read |
| dbg_data | output | 16 | Current contents of the selected register |

## Verification
The checker assumes that `instr_valid` stays low while reset is asserted and that `instr_word` is only meaningful when `instr_valid` is high. It also assumes that `dbg_idx` is a plain combinational select with no timing of its own. The bench holds the strobe low throughout reset and changes inputs only on falling edges. It mixes directed words, including illegal opcodes, bad complement padding and strobed-off legal words, with a long run of random operate words. A behavioural register model is compared against all eight registers, the condition register and the write-back view after every edge.

// File: rtl/opu_pkg.sv
package opu_pkg;

    localparam int INSTR_W = 16;
    localparam int IMM_W   = 5;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        K_NONE,
        K_ADD,
        K_AND,
        K_NOT
    } op_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_WB
    } wb_state_e;

endpackage

// File: rtl/opu_regfile.sv
module opu_regfile #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [IDX_W-1:0]  ra_a,
    output logic [DATA_W-1:0] rd_a,
    input  logic [IDX_W-1:0]  ra_b,
    output logic [DATA_W-1:0] rd_b,
    input  logic [IDX_W-1:0]  ra_d,
    output logic [DATA_W-1:0] rd_d
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (wa == IDX_W'(g))) begin
                regs[g] <= wd;
            end
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_d = regs[ra_d];

endmodule

// File: rtl/opu_decode.sv
module opu_decode
    import opu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    output op_kind_e           kind,
    output logic [IDX_W-1:0]   dst,
    output logic [IDX_W-1:0]   src_a,
    output logic [IDX_W-1:0]   src_b,
    output logic               use_imm,
    output logic [DATA_W-1:0]  imm
);

    logic [3:0] opc;

    assign opc     = instr_word[15:12];
    assign dst     = instr_word[11:9];
    assign src_a   = instr_word[8:6];
    assign src_b   = instr_word[2:0];
    assign use_imm = instr_word[5];
    assign imm     = {{(DATA_W-IMM_W){instr_word[IMM_W-1]}}, instr_word[IMM_W-1:0]};

    always_comb begin
        kind = K_NONE;
        if (instr_valid) begin
            unique case (opc)
                OPC_ADD: kind = K_ADD;
                OPC_AND: kind = K_AND;
                OPC_NOT: kind = (instr_word[5:0] == 6'b111111) ? K_NOT : K_NONE;
                default: kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        unique case (kind)
            K_ADD:   result = opnd_a + opnd_b;
            K_AND:   result = opnd_a & opnd_b;
            K_NOT:   result = ~opnd_a;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/opu_ccreg.sv
module opu_ccreg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [DATA_W-1:0] value,
    output logic [2:0]        cc
);

    logic [2:0] cc_next;

    always_comb begin
        if (value[DATA_W-1])  cc_next = 3'b100;
        else if (value == '0) cc_next = 3'b010;
        else                  cc_next = 3'b001;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cc <= 3'b010;
        else if (upd) cc <= cc_next;
    end

endmodule

// File: rtl/opu_core.sv
module opu_core
    import opu_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    output logic               wb_en,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [DATA_W-1:0]  wb_data,
    output logic [2:0]         cc_flags,
    input  logic [IDX_W-1:0]   dbg_idx,
    output logic [DATA_W-1:0]  dbg_data
);

    op_kind_e          kind;
    logic [IDX_W-1:0]  dst, src_a, src_b;
    logic              use_imm;
    logic [DATA_W-1:0] imm, rd_a, rd_b, opnd_b, result;
    logic              commit;
    wb_state_e         state_q, state_d;

    opu_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .kind        (kind),
        .dst         (dst),
        .src_a       (src_a),
        .src_b       (src_b),
        .use_imm     (use_imm),
        .imm         (imm)
    );

    opu_regfile #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (commit),
        .wa   (dst),
        .wd   (result),
        .ra_a (src_a),
        .rd_a (rd_a),
        .ra_b (src_b),
        .rd_b (rd_b),
        .ra_d (dbg_idx),
        .rd_d (dbg_data)
    );

    assign opnd_b = use_imm ? imm : rd_b;

    opu_alu #(.DATA_W(DATA_W)) u_alu (
        .kind   (kind),
        .opnd_a (rd_a),
        .opnd_b (opnd_b),
        .result (result)
    );

    assign commit = (kind != K_NONE);

    opu_ccreg #(.DATA_W(DATA_W)) u_cc (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (commit),
        .value(result),
        .cc   (cc_flags)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = commit ? ST_WB : ST_IDLE;
            ST_WB:   state_d = commit ? ST_WB : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_idx  <= '0;
            wb_data <= '0;
        end else if (commit) begin
            wb_idx  <= dst;
            wb_data <= result;
        end
    end

    assign wb_en = (state_q == ST_WB);

endmodule

// File: rtl/opu_core_chk.sv
module opu_core_chk #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [15:0]       instr_word,
    input logic              wb_en,
    input logic [IDX_W-1:0]  wb_idx,
    input logic [DATA_W-1:0] wb_data,
    input logic [2:0]        cc_flags,
    input logic [IDX_W-1:0]  dbg_idx,
    input logic [DATA_W-1:0] dbg_data
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cc_flags == 3'b010 && !wb_en));

    assert_cc_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_flags) == 1);

    assert_cc_follows_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (cc_flags == {wb_data[DATA_W-1], (wb_data == '0),
                                (!wb_data[DATA_W-1] && wb_data != '0)}));

    assert_idle_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !wb_en);

    assert_bad_opc_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_word[15:12] == 4'b0000) |=> !wb_en);

    assert_cc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |-> $stable(cc_flags));

    assert_bad_pad_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_word[15:12] == 4'b1001 && instr_word[5:0] != 6'b111111)
        |=> !wb_en);

    assert_wb_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && dbg_idx == wb_idx) |-> dbg_data == wb_data);

endmodule

bind opu_core opu_core_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/opu_core_tb_top.sv
`timescale 1ns/1ps
module opu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [15:0] wb_data;
    logic [2:0]  cc_flags;
    logic [2:0]  dbg_idx;
    logic [15:0] dbg_data;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] m_rf [8];
    logic [2:0]  m_cc;
    logic        m_wb_en;
    logic [2:0]  m_wb_idx;
    logic [15:0] m_wb_data;

    always #4 clk = ~clk;

    opu_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_valid(instr_valid),
        .instr_word (instr_word),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .cc_flags   (cc_flags),
        .dbg_idx    (dbg_idx),
        .dbg_data   (dbg_data)
    );

    function automatic logic [15:0] f_add_r(int d, int a, int b);
        return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] f_add_i(int d, int a, int k);
        return {4'b0001, 3'(d), 3'(a), 1'b1, 5'(k)};
    endfunction
    function automatic logic [15:0] f_and_r(int d, int a, int b);
        return {4'b0101, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] f_and_i(int d, int a, int k);
        return {4'b0101, 3'(d), 3'(a), 1'b1, 5'(k)};
    endfunction
    function automatic logic [15:0] f_not(int d, int a);
        return {4'b1001, 3'(d), 3'(a), 6'b111111};
    endfunction

    task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check16({req, " R7"}, "cc_flags", 16'(cc_flags), 16'(m_cc));
        check16({req, " R10"}, "wb_en", 16'(wb_en), 16'(m_wb_en));
        if (m_wb_en) begin
            check16({req, " R10"}, "wb_idx", 16'(wb_idx), 16'(m_wb_idx));
            check16({req, " R10"}, "wb_data", wb_data, m_wb_data);
        end
        for (int i = 0; i < 8; i++) begin
            dbg_idx = 3'(i);
            #0.1;
            check16({req, " R11"}, $sformatf("reg%0d", i), dbg_data, m_rf[i]);
        end
    endtask

    task automatic model_step(logic [15:0] w, logic v);
        logic [3:0]  opc;
        logic [15:0] a, b, res;
        bit          ok;
        opc = w[15:12];
        a   = m_rf[w[8:6]];
        b   = w[5] ? {{11{w[4]}}, w[4:0]} : m_rf[w[2:0]];
        ok  = 1'b1;
        res = '0;
        if (!v) ok = 1'b0;
        else if (opc == 4'b0001) res = a + b;
        else if (opc == 4'b0101) res = a & b;
        else if (opc == 4'b1001 && w[5:0] == 6'h3f) res = ~a;
        else ok = 1'b0;
        m_wb_en = ok;
        if (ok) begin
            m_rf[w[11:9]] = res;
            m_wb_idx      = w[11:9];
            m_wb_data     = res;
            m_cc          = res[15] ? 3'b100 : (res == 16'h0) ? 3'b010 : 3'b001;
        end
    endtask

    task automatic issue(logic [15:0] w, logic v, string req);
        instr_word  = w;
        instr_valid = v;
        @(posedge clk);
        model_step(w, v);
        @(negedge clk);
        instr_valid = 1'b0;
        check_all(req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        instr_valid = 1'b0;
        instr_word  = '0;
        dbg_idx     = '0;
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        m_cc = 3'b010; m_wb_en = 1'b0; m_wb_idx = '0; m_wb_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        issue(f_add_i(1, 0, 5),   1'b1, "R3");
        issue(f_add_i(2, 1, -16), 1'b1, "R3");
        issue(f_add_r(3, 1, 2),   1'b1, "R2");
        issue(f_and_i(4, 3, 7),   1'b1, "R4");
        issue(f_and_r(5, 3, 1),   1'b1, "R4");
        issue(f_not(6, 5),        1'b1, "R5");
        issue(f_add_i(6, 6, 1),   1'b1, "R6");
        issue(f_add_r(1, 1, 1),   1'b1, "R6");
        issue(f_add_i(7, 1, 0),   1'b1, "R3");
        issue(f_and_i(7, 7, 0),   1'b1, "R4");
        issue(f_not(2, 2),        1'b1, "R6");
        issue(16'h0E3F,           1'b1, "R8");
        issue(16'h2A3F,           1'b1, "R8");
        issue(16'hF025,           1'b1, "R8");
        issue(f_add_i(1, 1, 3),   1'b0, "R8");
        issue({4'b1001, 3'd1, 3'd2, 6'h3e}, 1'b1, "R9");
        issue({4'b1001, 3'd3, 3'd3, 6'h1f}, 1'b1, "R9");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            logic [15:0] w;
            r = $urandom;
            unique case (r[2:0])
                3'd0: w = f_add_r(int'(r[5:3]), int'(r[8:6]), int'(r[11:9]));
                3'd1: w = f_add_i(int'(r[5:3]), int'(r[8:6]), int'(r[16:12]));
                3'd2: w = f_and_r(int'(r[5:3]), int'(r[8:6]), int'(r[11:9]));
                3'd3: w = f_and_i(int'(r[5:3]), int'(r[8:6]), int'(r[16:12]));
                3'd4, 3'd5: w = f_not(int'(r[5:3]), int'(r[8:6]));
                default: w = r[31:16];
            endcase
            issue(w, (r[19:17] != 3'd0), "R2 R3 R4 R5 R8 R9");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule